// File: doc/BRIEF.md
# Converter Write Stretcher with Channel Hold

This block sits between a fast 8-bit processor bus and a successive-approximation converter that runs from an external clock. That converter needs a write strobe far longer than a processor bus cycle, because the autozero phase must finish while the write is held low. The block sees a qualified processor write and starts a one-shot timer. The timer drives a stretched, active-low write to the converter for a fixed number of system clock cycles. For the whole pulse, the converter's chip select and two-bit channel address are frozen at the values captured when the write started. The processor's own cycle is never held up.

When no stretched write is running, chip select, the channel bits and the read strobe pass straight through to the converter, so reads work as if the block were not there. The byte-select line is never latched. The pulse length is the parameter `STRETCH_CYCLES`. Its default of 1250 cycles gives 10 µs at a 125 MHz system clock. A write that arrives while a pulse is running is dropped; it neither restarts nor extends the pulse.

Top module: `wr_stretch_top`

## Requirements
- R1: A stretched write starts at a rising clock edge where `bus_cs_n`=0, `bus_wr_n`=0 and `bus_addr_ok`=1, if that same condition was false at the previous edge and no pulse is running. `adc_wr_n` goes low right after that edge.
- R2: Once started, `adc_wr_n` stays low for exactly `STRETCH_CYCLES` clock cycles and then returns high.
- R3: A write with `bus_addr_ok`=0 never starts a stretched write.
- R4: While the pulse runs, `adc_chan` holds the channel value sampled at the starting edge and `adc_cs_n` stays 0, whatever the bus does.
- R5: While no pulse runs, `adc_chan` equals `bus_chan` and `adc_cs_n` equals `bus_cs_n` in the same cycle.
- R6: A new qualified write edge during a running pulse is ignored. A write still held low when the pulse ends does not start another pulse, because a fresh edge of the qualified-write condition is needed.
- R7: `adc_bsel` always equals `bus_bsel`, during a pulse and outside one.
- R8: `adc_rd_n` equals `bus_rd_n` while no pulse runs and is forced to 1 while a pulse runs.
- R9: While `rst_n`=0 and after its release, `adc_wr_n`=1 and no pulse runs until a write starts one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs_n | input | 1 | Decoded converter select from the processor bus, active low |
| bus_wr_n | input | 1 | Processor write strobe, active low |
| bus_rd_n | input | 1 | Processor read strobe, active low |
| bus_addr_ok | input | 1 | Valid-address qualifier, high when the bus address is stable |
| bus_chan | input | 2 | Channel select bits from the bus |
| bus_bsel | input | 1 | Byte select from the bus |
| adc_cs_n | output | 1 | Chip select to the converter |
| adc_wr_n | output | 1 | Stretched write to the converter |
| adc_rd_n | output | 1 | Read strobe to the converter |
| adc_chan | output | 2 | Channel select to the converter |
| adc_bsel | output | 1 | Byte select to the converter |

## Verification
Several properties are checked on every cycle:
- a pulse begins only after a start event;
- a start event needs the address qualifier;
- the timer keeps running until its count is used up;
- the captured channel stays still during a pulse;
- the read strobe is blocked during a pulse.

Other properties can only be shown by the bench's scenarios, using its clock-by-clock reference model:
- the exact pulse length;
- that retriggers are refused;
- that a write held across the end of a pulse does not start another;
- the passthrough behaviour between pulses.

// File: rtl/wr_stretch_pkg.sv
package wr_stretch_pkg;
  localparam int CHAN_BITS = 2;

  typedef struct packed {
    logic                 cs_n;
    logic [CHAN_BITS-1:0] chan;
  } sel_t;
endpackage

// File: rtl/wr_stretch_trig.sv
module wr_stretch_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic wr_n,
  input  logic addr_ok,
  output logic fire
);
  logic req, req_q;

  assign req  = ~cs_n & ~wr_n & addr_ok;
  assign fire = req & ~req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req;
  end
endmodule

// File: rtl/wr_stretch_timer.sv
module wr_stretch_timer #(
  parameter int STRETCH_CYCLES = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active,
  output logic load
);
  localparam int CW = $clog2(STRETCH_CYCLES + 1);
  localparam logic [CW-1:0] RELOAD = CW'(STRETCH_CYCLES - 1);

  logic [CW-1:0] count;

  assign load = fire & ~active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      count  <= '0;
    end else if (load) begin
      active <= 1'b1;
      count  <= RELOAD;
    end else if (active) begin
      if (count == '0) active <= 1'b0;
      else             count  <= count - 1'b1;
    end
  end

  // R2
  timer_keeps_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && count != '0) |=> active);

  // R6
  no_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && count != '0) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/wr_stretch_hold.sv
module wr_stretch_hold
  import wr_stretch_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic capture,
  input  logic active,
  input  sel_t bus_sel,
  output sel_t adc_sel
);
  sel_t held;

  always_ff @(posedge clk) begin
    if (!rst_n)       held <= '{cs_n: 1'b1, chan: '0};
    else if (capture) held <= bus_sel;
  end

  assign adc_sel = active ? held : bus_sel;

  // R4
  held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(held));
endmodule

// File: rtl/wr_stretch_top.sv
module wr_stretch_top
  import wr_stretch_pkg::*;
#(
  parameter int STRETCH_CYCLES = 1250
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_cs_n,
  input  logic                 bus_wr_n,
  input  logic                 bus_rd_n,
  input  logic                 bus_addr_ok,
  input  logic [CHAN_BITS-1:0] bus_chan,
  input  logic                 bus_bsel,
  output logic                 adc_cs_n,
  output logic                 adc_wr_n,
  output logic                 adc_rd_n,
  output logic [CHAN_BITS-1:0] adc_chan,
  output logic                 adc_bsel
);
  logic fire, active, load;
  sel_t bus_sel, adc_sel;

  wr_stretch_trig u_trig (
    .clk(clk), .rst_n(rst_n), .cs_n(bus_cs_n), .wr_n(bus_wr_n),
    .addr_ok(bus_addr_ok), .fire(fire)
  );

  wr_stretch_timer #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .fire(fire), .active(active), .load(load)
  );

  assign bus_sel = '{cs_n: bus_cs_n, chan: bus_chan};

  wr_stretch_hold u_hold (
    .clk(clk), .rst_n(rst_n), .capture(load), .active(active),
    .bus_sel(bus_sel), .adc_sel(adc_sel)
  );

  assign adc_cs_n = adc_sel.cs_n;
  assign adc_chan = adc_sel.chan;
  assign adc_wr_n = ~active;
  assign adc_rd_n = bus_rd_n | active;
  assign adc_bsel = bus_bsel;

  // R1
  start_needs_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(fire));

  // R3
  fire_needs_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> bus_addr_ok);

  // R8
  read_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_wr_n |-> adc_rd_n);
endmodule

// File: tb/wr_stretch_top_tb.sv
module wr_stretch_top_tb;
  localparam int W = 1250;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_cs_n = 1'b1, bus_wr_n = 1'b1, bus_rd_n = 1'b1, bus_addr_ok = 1'b0;
  logic [1:0] bus_chan = 2'd0;
  logic bus_bsel = 1'b0;
  logic adc_cs_n, adc_wr_n, adc_rd_n, adc_bsel;
  logic [1:0] adc_chan;

  int errors = 0, checks = 0;
  int remaining = 0;
  bit prev_req = 0;
  logic [1:0] held_chan = 2'd0;
  int low_run = 0;
  int pulses = 0;
  int cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wr_stretch_top #(.STRETCH_CYCLES(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n),
    .bus_rd_n(bus_rd_n), .bus_addr_ok(bus_addr_ok), .bus_chan(bus_chan),
    .bus_bsel(bus_bsel), .adc_cs_n(adc_cs_n), .adc_wr_n(adc_wr_n),
    .adc_rd_n(adc_rd_n), .adc_chan(adc_chan), .adc_bsel(adc_bsel)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // reference model, updated at each rising edge
  always @(posedge clk) begin
    bit req;
    cycles++;
    req = !bus_cs_n && !bus_wr_n && bus_addr_ok;
    if (!rst_n) begin
      remaining = 0;
      prev_req  = 0;
    end else begin
      if (remaining > 0) remaining--;
      else if (req && !prev_req) begin
        remaining = W;
        held_chan = bus_chan;
      end
      prev_req = req;
    end
  end

  // comparison on every falling edge
  always @(negedge clk) begin
    bit act;
    act = remaining > 0;
    check(adc_wr_n == !act, act ? "R1" : "R9", adc_wr_n, !act);
    check(adc_bsel == bus_bsel, "R7", adc_bsel, bus_bsel);
    check(adc_rd_n == (act ? 1'b1 : bus_rd_n), "R8", adc_rd_n, act ? 1 : bus_rd_n);
    if (act) begin
      check(adc_chan == held_chan, "R4", adc_chan, held_chan);
      check(adc_cs_n == 1'b0, "R4", adc_cs_n, 0);
    end else begin
      check(adc_chan == bus_chan, "R5", adc_chan, bus_chan);
      check(adc_cs_n == bus_cs_n, "R5", adc_cs_n, bus_cs_n);
    end
    if (!adc_wr_n) low_run++;
    else if (low_run != 0) begin
      pulses++;
      check(low_run == W, "R2", low_run, W);
      low_run = 0;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic idle();
    bus_cs_n = 1'b1; bus_wr_n = 1'b1; bus_rd_n = 1'b1; bus_addr_ok = 1'b0;
  endtask

  task automatic bus_write(input logic [1:0] ch, input logic ok, input int len);
    bus_cs_n = 1'b0; bus_wr_n = 1'b0; bus_addr_ok = ok; bus_chan = ch;
    step(len);
    idle();
  endtask

  task automatic bus_read(input logic [1:0] ch, input logic bs, input int len);
    bus_cs_n = 1'b0; bus_rd_n = 1'b0; bus_addr_ok = 1'b1; bus_chan = ch; bus_bsel = bs;
    step(len);
    idle();
  endtask

  initial begin
    step(4);
    check(adc_wr_n == 1'b1, "R9", adc_wr_n, 1);
    rst_n = 1'b1;
    step(3);
    // passthrough reads, both byte selects
    bus_read(2'd1, 1'b0, 3);
    bus_read(2'd3, 1'b1, 3);
    step(2);
    // R3: unqualified write
    bus_write(2'd2, 1'b0, 4);
    step(20);
    check(pulses == 0 && adc_wr_n == 1'b1, "R3", adc_wr_n, 1);
    // R1/R4: qualified write, bus then wanders
    bus_write(2'd2, 1'b1, 3);
    bus_chan = 2'd1; bus_bsel = 1'b1;
    step(100);
    bus_read(2'd0, 1'b0, 4);
    // R6: retrigger attempt during pulse
    step(200);
    bus_write(2'd3, 1'b1, 3);
    step(W);
    check(pulses == 1, "R6", pulses, 1);
    step(10);
    // R6: write held low across pulse end
    bus_cs_n = 1'b0; bus_wr_n = 1'b0; bus_addr_ok = 1'b1; bus_chan = 2'd0;
    step(W + 200);
    idle();
    step(50);
    check(pulses == 2, "R6", pulses, 2);
    // back-to-back after end, new channel
    bus_write(2'd3, 1'b1, 2);
    step(W + 20);
    check(pulses == 3, "R2", pulses, 3);
    bus_read(2'd2, 1'b1, 3);
    step(5);
    done = 1;
  end

  initial begin
    int wd;
    wd = 0;
    while (!done && wd < 100000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=done", wd);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule